// File: doc/BRIEF.md
# Multi-Mode Sprite Renderer (32x32)

This block paints a 32x32 frame buffer from a list of sprite entries kept in a small local RAM. A host writes 16-bit words into the sprite RAM. Two consecutive words form one 32-bit entry. A one-cycle update strobe then starts a pass over all entries in address order. During the pass, each entry is decoded according to its 3-bit mode field and drawn into the frame buffer.

Three entry layouts are supported: a single point with 6-bit channels, a filled rectangle with 3-bit channels, and a single point with 5-bit channels plus a transparency flag. All colours are widened to one internal 18-bit format. The frame buffer is never cleared by a pass, so a scene can be built up over several updates. Any pixel can be read back combinationally through a read port.

Top module: `sprite_render32`

## Requirements
- R1: Entry n is made of sprite RAM words 2n and 2n+1. Word 2n supplies entry bits 31:16 and word 2n+1 supplies bits 15:0.
- R2: Entry bits 31:29 are the mode. Mode values 0, 4, 5, 6 and 7 write no pixel.
- R3: Mode 1 takes x from bits 27:23, y from 22:18, and red/green/blue from 17:12, 11:6 and 5:0. It writes exactly one pixel.
- R4: Mode 2 takes x1 from 28:24, x2 from 23:19, y1 from 18:14 and y2 from 13:9, with 3-bit red/green/blue in 8:6, 5:3 and 2:0. It fills every pixel with x1<=x<=x2 and y1<=y<=y2. Each 3-bit channel c becomes the 6-bit value {c,c}.
- R5: Mode 3 takes x from 25:21, y from 20:16, and 5-bit red/green/blue from 15:11, 10:6 and 5:1. Each 5-bit channel c becomes {c,c[4]}. Bit 0 set to 1 marks the entry transparent, and then no pixel is written.
- R6: A mode 2 entry with x1>x2 or y1>y2 writes no pixel.
- R7: Entries are drawn in increasing index order, so a later entry overwrites an earlier one where they overlap.
- R8: Reset sets every frame buffer pixel to 0. A pass leaves untouched any pixel that no entry writes.
- R9: Pixel (x,y) is read at read address {y,x} as {red,green,blue}, each channel 6 bits wide.
- R10: busy is high from the cycle after update until the pass ends. done is high for exactly one cycle, in the first cycle in which busy is low again. An update strobe during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sprWrEn | input | 1 | Sprite RAM word write enable |
| sprWrAddr | input | 6 | Sprite RAM word address |
| sprWrData | input | 16 | Sprite RAM word data |
| update | input | 1 | Start a drawing pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at end of pass |
| pixRdAddr | input | 10 | Pixel read address {y,x} |
| pixRdData | output | 18 | Pixel colour {r,g,b} |

## Verification
The assertions assume that the sprite RAM is not written while busy is high, and that pixels are read only while the block is idle. The stimulus loads all 64 words before each update and reads the frame only after done. Apart from these two rules, the stimulus is free: it covers every mode value and rectangles whose arithmetic may turn them inverted or push them to the screen edges. It also includes a second update strobe issued in the middle of a pass.

// File: rtl/sprite_render32_pkg.sv
package sprite_render32_pkg;
  localparam int COORD_W = 5;
  localparam int CH_W    = 6;
  localparam int PIX_W   = 3 * CH_W;
  localparam int FB_AW   = 2 * COORD_W;
  localparam int FB_SIZE = 1 << FB_AW;

  typedef struct packed {
    logic clrIdx;
    logic loadEntry;
    logic stepPix;
    logic nextIdx;
  } rend_strobe_t;
endpackage

// File: rtl/sprite_render32_ctrl.sv
module sprite_render32_ctrl
  import sprite_render32_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         update,
  input  logic         drawOk,
  input  logic         atEnd,
  input  logic         lastIdx,
  output rend_strobe_t stb,
  output logic         busy,
  output logic         done
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DRAW} state_t;
  state_t st, stNext;
  logic finish;

  always_comb begin
    stb    = '0;
    stNext = st;
    finish = 1'b0;
    case (st)
      S_IDLE: if (update) begin
        stb.clrIdx = 1'b1;
        stNext     = S_LOAD;
      end
      S_LOAD: begin
        stb.loadEntry = 1'b1;
        stNext        = S_DRAW;
      end
      S_DRAW: begin
        stb.stepPix = drawOk;
        if (!drawOk || atEnd) begin
          if (lastIdx) begin
            finish = 1'b1;
            stNext = S_IDLE;
          end else begin
            stb.nextIdx = 1'b1;
            stNext      = S_LOAD;
          end
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
    end else begin
      st   <= stNext;
      done <= finish;
    end
  end

  assign busy = (st != S_IDLE);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_end_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r6_no_step_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    stb.stepPix |-> drawOk);
endmodule

// File: rtl/sprite_render32_dp.sv
module sprite_render32_dp
  import sprite_render32_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WA_W   = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sprWrEn,
  input  logic [WA_W-1:0]  sprWrAddr,
  input  logic [15:0]      sprWrData,
  input  logic [FB_AW-1:0] pixRdAddr,
  output logic [PIX_W-1:0] pixRdData,
  input  rend_strobe_t     stb,
  output logic             drawOk,
  output logic             atEnd,
  output logic             lastIdx
);
  logic [15:0]        sprRam [2*ENTRIES];
  logic [PIX_W-1:0]   frame  [FB_SIZE];
  logic [IDX_W-1:0]   idx;
  logic [31:0]        ent;
  logic [2:0]         mode;
  logic [COORD_W-1:0] dXLo, dXHi, dYLo, dYHi;
  logic [PIX_W-1:0]   dCol;
  logic               dOk;
  logic [COORD_W-1:0] xLo, xHi, yLo, yHi, cx, cy;
  logic [PIX_W-1:0]   col;

  always_ff @(posedge clk)
    if (sprWrEn) sprRam[sprWrAddr] <= sprWrData;

  assign ent     = {sprRam[{idx, 1'b0}], sprRam[{idx, 1'b1}]};
  assign mode    = ent[31:29];
  assign lastIdx = (idx == IDX_W'(ENTRIES - 1));

  always_comb begin
    dXLo = ent[27:23];
    dXHi = ent[27:23];
    dYLo = ent[22:18];
    dYHi = ent[22:18];
    dCol = ent[17:0];
    dOk  = 1'b0;
    case (mode)
      3'd1: dOk = 1'b1;
      3'd2: begin
        dXLo = ent[28:24];
        dXHi = ent[23:19];
        dYLo = ent[18:14];
        dYHi = ent[13:9];
        dCol = {ent[8:6], ent[8:6], ent[5:3], ent[5:3], ent[2:0], ent[2:0]};
        dOk  = (ent[28:24] <= ent[23:19]) && (ent[18:14] <= ent[13:9]);
      end
      3'd3: begin
        dXLo = ent[25:21];
        dXHi = ent[25:21];
        dYLo = ent[20:16];
        dYHi = ent[20:16];
        dCol = {ent[15:11], ent[15], ent[10:6], ent[10], ent[5:1], ent[5]};
        dOk  = !ent[0];
      end
      default: dOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      drawOk <= 1'b0;
      xLo <= '0; xHi <= '0; yLo <= '0; yHi <= '0;
      cx  <= '0; cy  <= '0; col <= '0;
    end else begin
      if (stb.clrIdx)  idx <= '0;
      if (stb.nextIdx) idx <= idx + 1'b1;
      if (stb.loadEntry) begin
        xLo <= dXLo; xHi <= dXHi; yLo <= dYLo; yHi <= dYHi;
        cx  <= dXLo; cy  <= dYLo;
        col <= dCol; drawOk <= dOk;
      end else if (stb.stepPix) begin
        if (cx == xHi) begin
          cx <= xLo;
          cy <= cy + 1'b1;
        end else begin
          cx <= cx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FB_SIZE; i++) frame[i] <= '0;
    end else if (stb.stepPix) begin
      frame[{cy, cx}] <= col;
    end
  end

  assign atEnd     = (cx == xHi) && (cy == yHi);
  assign pixRdData = frame[pixRdAddr];

  a_r4_step_in_box: assert property (@(posedge clk) disable iff (!rst_n)
    stb.stepPix |-> (cx >= xLo && cx <= xHi && cy >= yLo && cy <= yHi));
  a_r7_index_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    stb.nextIdx |-> !lastIdx);
  a_r1_ram_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.loadEntry || stb.stepPix) |-> !sprWrEn);
endmodule

// File: rtl/sprite_render32.sv
module sprite_render32
  import sprite_render32_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sprWrEn,
  input  logic [5:0]  sprWrAddr,
  input  logic [15:0] sprWrData,
  input  logic        update,
  output logic        busy,
  output logic        done,
  input  logic [9:0]  pixRdAddr,
  output logic [17:0] pixRdData
);
  rend_strobe_t stb;
  logic drawOk, atEnd, lastIdx;

  sprite_render32_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .update(update), .drawOk(drawOk),
    .atEnd(atEnd), .lastIdx(lastIdx), .stb(stb), .busy(busy), .done(done)
  );

  sprite_render32_dp #(.ENTRIES(32)) u_dp (
    .clk(clk), .rst_n(rst_n), .sprWrEn(sprWrEn), .sprWrAddr(sprWrAddr),
    .sprWrData(sprWrData), .pixRdAddr(pixRdAddr), .pixRdData(pixRdData),
    .stb(stb), .drawOk(drawOk), .atEnd(atEnd), .lastIdx(lastIdx)
  );
endmodule

// File: tb/sprite_render32_bench.sv
module sprite_render32_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sprWrEn = 1'b0;
  logic [5:0]  sprWrAddr = '0;
  logic [15:0] sprWrData = '0;
  logic        update = 1'b0;
  logic        busy, done;
  logic [9:0]  pixRdAddr = '0;
  logic [17:0] pixRdData;

  int checks = 0;
  int fails  = 0;
  logic [17:0] model [1024];
  logic [31:0] ents  [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  sprite_render32 u_sprite_render32 (
    .clk(clk), .rst_n(rst_n), .sprWrEn(sprWrEn), .sprWrAddr(sprWrAddr),
    .sprWrData(sprWrData), .update(update), .busy(busy), .done(done),
    .pixRdAddr(pixRdAddr), .pixRdData(pixRdData)
  );

  function automatic logic [31:0] mk1(int x, int y, int r, int g, int b);
    return {3'd1, 1'b0, 5'(x), 5'(y), 6'(r), 6'(g), 6'(b)};
  endfunction
  function automatic logic [31:0] mk2(int x1, int x2, int y1, int y2, int r, int g, int b);
    return {3'd2, 5'(x1), 5'(x2), 5'(y1), 5'(y2), 3'(r), 3'(g), 3'(b)};
  endfunction
  function automatic logic [31:0] mk3(int x, int y, int r, int g, int b, int a);
    return {3'd3, 3'b101, 5'(x), 5'(y), 5'(r), 5'(g), 5'(b), 1'(a)};
  endfunction

  // Model of R2..R7, applied in index order.
  task automatic modelApply(input logic [31:0] e);
    int m = int'(e[31:29]);
    if (m == 1) begin
      model[{e[22:18], e[27:23]}] = e[17:0];
    end else if (m == 2) begin
      for (int y = int'(e[18:14]); y <= int'(e[13:9]); y++)
        for (int x = int'(e[28:24]); x <= int'(e[23:19]); x++)
          model[y*32 + x] = {e[8:6], e[8:6], e[5:3], e[5:3], e[2:0], e[2:0]};
    end else if (m == 3) begin
      if (!e[0])
        model[{e[20:16], e[25:21]}] =
          {e[15:11], e[15], e[10:6], e[10], e[5:1], e[5]};
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadEntries();
    for (int i = 0; i < 32; i++) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        sprWrEn   = 1'b1;
        sprWrAddr = 6'(2*i + w);
        sprWrData = (w == 0) ? ents[i][31:16] : ents[i][15:0];
      end
      modelApply(ents[i]);
    end
    @(negedge clk);
    sprWrEn = 1'b0;
  endtask

  task automatic runPass();
    int n = 0;
    @(negedge clk); update = 1'b1;
    @(negedge clk); update = 1'b0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check(1'b0, "R10 watchdog", n, 0);
  endtask

  task automatic compareFrame(input string req);
    int bad = 0, firstA = 0, firstE = 0, firstI = 0;
    for (int i = 0; i < 1024; i++) begin
      pixRdAddr = 10'(i);
      #1;
      if (pixRdData !== model[i]) begin
        if (bad == 0) begin
          firstA = int'(pixRdData); firstE = int'(model[i]); firstI = i;
        end
        bad++;
      end
    end
    if (bad != 0) $display("  pixel %0d mismatched (%0d total)", firstI, bad);
    check(bad == 0, req, firstA, firstE);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    check(busy == 0 && done == 0, "R10 idle after reset", {busy, done}, 0);
    compareFrame("R8 reset clears frame");

    // R3 R1 R9: points on a diagonal sweep, several colour patterns
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 32; i++)
        ents[i] = mk1(i, (i*3 + k*7) % 32, i*2 + k, 63 - i, (i*5 + k) % 64);
      loadEntries();
      runPass();
      compareFrame("R3 mode1 points / R1 word order / R9 read address");
    end

    // R4 R6 R7: rectangle sweeps, some inverted, overlapping
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 32; i++)
        ents[i] = mk2((i*7 + k) % 32, (i*7 + k + (i % 6) - 1) % 32,
                      (i*5 + 3*k) % 32, (i*5 + 3*k + (i % 4)) % 32,
                      i % 8, (i + k) % 8, (7 - i) % 8);
      loadEntries();
      runPass();
      compareFrame("R4 R6 R7 rectangle sweep");
    end

    // R4 boundary: full screen then corner rectangles overwrite it (R7)
    for (int i = 0; i < 32; i++) ents[i] = {3'd0, 29'h0};
    ents[0] = mk2(0, 31, 0, 31, 1, 2, 3);
    ents[1] = mk2(31, 31, 0, 31, 7, 0, 5);
    ents[2] = mk2(0, 31, 31, 31, 4, 6, 1);
    ents[3] = mk2(5, 4, 0, 31, 7, 7, 7);     // inverted x
    ents[4] = mk2(0, 31, 9, 8, 7, 7, 7);     // inverted y
    loadEntries();
    runPass();
    compareFrame("R4 full screen / R6 inverted rect");

    // R5: mode 3 with both alpha values, later entry overwriting
    for (int i = 0; i < 32; i++)
      ents[i] = mk3(i % 16, (i / 2) % 32, i, 31 - i, (i*3) % 32, i % 3 == 0);
    loadEntries();
    runPass();
    compareFrame("R5 mode3 widen and transparency");

    // R2: every undrawn mode value, R8 frame persists
    for (int i = 0; i < 32; i++) begin
      logic [2:0] m;
      m = (i % 5 == 0) ? 3'd0 : 3'(3 + i % 5);
      ents[i] = {m, 29'h1fff_ffff ^ 29'(i * 12345)};
    end
    loadEntries();
    runPass();
    compareFrame("R2 ignored modes / R8 persistence");

    // R10: handshake timing and ignored re-trigger
    for (int i = 0; i < 32; i++) ents[i] = mk1(i, 31 - i, 1, 2, i);
    ents[31] = mk2(0, 3, 0, 3, 5, 5, 5);
    loadEntries();
    begin
      int n = 0;
      @(negedge clk); update = 1'b1;
      @(negedge clk); update = 1'b0;
      check(busy == 1, "R10 busy after update", busy, 1);
      repeat (3) @(negedge clk);
      update = 1'b1;
      @(negedge clk); update = 1'b0;
      while (!done && n < 5000) begin
        check(busy == 1, "R10 busy through pass", busy, 1);
        @(negedge clk);
        n++;
      end
      check(done == 1 && busy == 0, "R10 done with busy low", {done, busy}, 2);
      @(negedge clk);
      check(done == 0, "R10 done lasts one cycle", done, 0);
      n = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (busy || done) n++;
      end
      check(n == 0, "R10 update during pass ignored", n, 0);
    end
    compareFrame("R10 pass result");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule